// File: doc/BRIEF.md
# Banked Synchronous RAM Wrapper

This block provides 4.5 kbit of on-chip storage organised as eight separate banks. Each bank holds 64 words of 9 bits and has its own address, chip enable, write enable, write data and read data. Every input is captured in a register before it reaches the storage array, and every read data output leaves from a register. To the surrounding logic the memory is therefore fully synchronous: inputs may change at any point between clock edges, and outputs change only just after a rising edge.

Inside each bank a single internal data line is steered by the registered write enable. During a write it carries the registered write data into the array. During a read it carries the addressed word toward the output register. The output register loads only at the end of a read cycle, so after a write, or while the bank is idle, the bank keeps presenting the last word it read. The banks share only the clock and reset and may be read and written in the same cycle.

Top module: `banked_sync_ram`

## Requirements
- R1: A synchronous active-low reset clears the registered enables and every read data output to zero; right after reset is released, all read data outputs read zero.
- R2: A write to bank b stores the 9-bit write data at the 6-bit address. A later read of that address returns it. The port slices of bank b are bits [b*6 +: 6] of the address bus and bits [b*9 +: 9] of the write and read data buses.
- R3: The read data of a bank changes exactly two rising edges after the read command (chip enable 1, write enable 0) is presented at the pins. After one edge it still shows the previous value.
- R4: While chip enable is 0, the bank ignores write enable, address and data. Nothing is stored, and the read data two edges later is unchanged.
- R5: A write cycle does not disturb the read data output, which keeps the last word read.
- R6: The eight banks are independent. Any mix of reads, writes and idle cycles across banks in the same cycle gives each bank the result it would give alone.
- R7: A read presented on the cycle right after a write to the same address returns the newly written word.
- R8: All 64 addresses of a bank are distinct storage locations, including the lowest (0) and highest (63).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_ce | input | 8 | Chip enable, one bit per bank |
| bank_we | input | 8 | Write enable (1 write, 0 read), one bit per bank |
| bank_addr | input | 48 | Word address, 6 bits per bank |
| bank_wdata | input | 72 | Write data, 9 bits per bank |
| bank_rdata | output | 72 | Registered read data, 9 bits per bank |

## Verification
The bench builds the block with its default parameters: eight banks, 6-bit addresses and 9-bit words. At these values a full fill of every word takes only 64 cycles, so the whole array can be preloaded and then hit at random. Because the address space is small, random traffic often reaches the edge words and lands on addresses that were just written, which exercises back-to-back write-read and bank collisions in the same cycle. All eight read outputs are compared on every cycle against a bench model that derives from the requirements the two-edge latency and the rule that only a read loads the output.

// File: rtl/brb_pkg.sv
// Shared definitions for the banked synchronous RAM wrapper.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package brb_pkg;

    // Registered command of one bank.
    typedef struct packed {
        logic ce;   // bank selected this cycle
        logic we;   // 1 = write, 0 = read
    } bank_cmd_t;

endpackage

// File: rtl/brb_in_reg.sv
// Input capture stage of one bank: registers the enables, address and write
// data so the array sees stable values for a whole cycle.
// Assumes: synchronous active-low reset; address and data need no reset.
module brb_in_reg
    import brb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_in,
    input  logic              we_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] din_in,
    output bank_cmd_t         cmd_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q
);

    // Capture the command bits; reset leaves the bank idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q.ce <= ce_in;
            cmd_q.we <= we_in;
        end
    end

    // Capture address and write data every cycle.
    always_ff @(posedge clk) begin
        addr_q <= addr_in;
        din_q  <= din_in;
    end

endmodule

// File: rtl/brb_bank.sv
// One storage bank: word array, steered internal data line and a gated
// output register that only loads at the end of a read cycle.
// Assumes: inputs already registered by brb_in_reg; array is not reset.
module brb_bank
    import brb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_cmd_t         cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] data_line;
    logic              do_write;
    logic              do_read;

    // Decode the registered command.
    assign do_write = cmd.ce &  cmd.we;
    assign do_read  = cmd.ce & ~cmd.we;

    // Steer the internal line: write data in a write, array word otherwise.
    assign data_line = cmd.we ? din : mem[addr];

    // Store the line into the array on an enabled write.
    always_ff @(posedge clk) begin
        if (do_write) begin
            mem[addr] <= data_line;
        end
    end

    // Load the output register only after a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (do_read) begin
            dout_q <= data_line;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout_q == '0) && !cmd.ce);

    // R4
    no_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_read |=> $stable(dout_q));

    // R5
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.ce && cmd.we) |=> $stable(dout_q));

endmodule

// File: rtl/banked_sync_ram.sv
// Banked synchronous RAM: NUM_BANKS independent banks, each with registered
// inputs and a registered, read-gated output. Ports are packed per bank.
// Assumes: one clock domain, synchronous active-low reset.
module banked_sync_ram
    import brb_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS-1:0]          bank_ce,
    input  logic [NUM_BANKS-1:0]          bank_we,
    input  logic [NUM_BANKS*ADDR_W-1:0]   bank_addr,
    input  logic [NUM_BANKS*DATA_W-1:0]   bank_wdata,
    output logic [NUM_BANKS*DATA_W-1:0]   bank_rdata
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_cmd_t         cmd_q;
        logic [ADDR_W-1:0] addr_q;
        logic [DATA_W-1:0] din_q;
        logic [DATA_W-1:0] dout;

        brb_in_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) in_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce_in   (bank_ce[b]),
            .we_in   (bank_we[b]),
            .addr_in (bank_addr[b*ADDR_W +: ADDR_W]),
            .din_in  (bank_wdata[b*DATA_W +: DATA_W]),
            .cmd_q   (cmd_q),
            .addr_q  (addr_q),
            .din_q   (din_q)
        );

        brb_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd    (cmd_q),
            .addr   (addr_q),
            .din    (din_q),
            .dout_q (dout)
        );

        assign bank_rdata[b*DATA_W +: DATA_W] = dout;

        // R4
        ce_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_ce[b] |=> ##1 $stable(bank_rdata[b*DATA_W +: DATA_W]));
    end

endmodule

// File: tb/banked_sync_ram_tb_top.sv
// Self-checking bench: preload, directed corner cases, then seeded random
// traffic, comparing all read outputs against a requirement model each cycle.
module banked_sync_ram_tb_top;

    localparam int NB = 8;
    localparam int AW = 6;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB-1:0]     ce = '0;
    logic [NB-1:0]     we = '0;
    logic [NB*AW-1:0]  addr = '0;
    logic [NB*DW-1:0]  wdata = '0;
    logic [NB*DW-1:0]  rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [DW-1:0] m_mem  [NB][DEPTH];
    logic [DW-1:0] m_dout [NB];
    logic          p_ce   [NB];
    logic          p_we   [NB];
    logic [AW-1:0] p_addr [NB];
    logic [DW-1:0] p_din  [NB];

    banked_sync_ram #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bank_ce(ce), .bank_we(we),
        .bank_addr(addr), .bank_wdata(wdata), .bank_rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] rd_slice(int b);
        return rdata[b*DW +: DW];
    endfunction

    task automatic set_bank(int b, logic c, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
        ce[b] = c;
        we[b] = w;
        addr[b*AW +: AW] = a;
        wdata[b*DW +: DW] = d;
    endtask

    task automatic check(string tag, int b, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s bank %0d: got %h expected %h", tag, b, got, exp);
        end
    endtask

    // One clock: advance the model at the edge, compare all banks mid-cycle.
    task automatic step(string tag);
        @(posedge clk);
        for (int b = 0; b < NB; b++) begin
            if (!rst_n) begin
                m_dout[b] = '0;
                p_ce[b] = 1'b0;
            end else begin
                if (p_ce[b] && p_we[b]) m_mem[b][p_addr[b]] = p_din[b];
                if (p_ce[b] && !p_we[b]) m_dout[b] = m_mem[b][p_addr[b]];
                p_ce[b] = ce[b];
            end
            p_we[b]   = we[b];
            p_addr[b] = addr[b*AW +: AW];
            p_din[b]  = wdata[b*DW +: DW];
        end
        @(negedge clk);
        for (int b = 0; b < NB; b++) check(tag, b, rd_slice(b), m_dout[b]);
    endtask

    task automatic idle_all();
        ce = '0;
        we = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) begin
            p_ce[b] = 1'b0; p_we[b] = 1'b0; p_addr[b] = '0; p_din[b] = '0; m_dout[b] = '0;
        end
        // R1: reset state
        step("R1");
        step("R1");
        rst_n = 1'b1;
        step("R1");
        for (int b = 0; b < NB; b++) check("R1", b, rd_slice(b), '0);

        // R2 / R8: preload every word of every bank with a distinct pattern
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 0; b < NB; b++)
                set_bank(b, 1'b1, 1'b1, AW'(a), DW'((a * 7 + b * 61 + 3) & 9'h1ff));
            step("R2");
        end
        idle_all();
        step("R5");
        step("R5");

        // R8: lowest and highest addresses hold different values
        set_bank(0, 1'b1, 1'b1, '0, 9'h0a5);
        set_bank(1, 1'b1, 1'b1, 6'd63, 9'h15a);
        step("R8");
        set_bank(0, 1'b1, 1'b1, 6'd63, 9'h1c3);
        set_bank(1, 1'b1, 1'b1, '0, 9'h03c);
        step("R8");
        set_bank(0, 1'b1, 1'b0, '0, '0);
        set_bank(1, 1'b1, 1'b0, 6'd63, '0);
        step("R8");
        set_bank(0, 1'b1, 1'b0, 6'd63, '0);
        set_bank(1, 1'b1, 1'b0, '0, '0);
        step("R8");
        idle_all();
        step("R8");
        check("R8", 0, rd_slice(0), 9'h1c3);
        check("R8", 1, rd_slice(1), 9'h03c);

        // R3: explicit latency on bank 2
        set_bank(2, 1'b1, 1'b1, 6'd10, 9'h111);
        step("R3");
        set_bank(2, 1'b1, 1'b0, 6'd10, '0);
        step("R3");
        idle_all();
        check("R3", 2, rd_slice(2), m_dout[2]);
        step("R3");
        check("R3", 2, rd_slice(2), 9'h111);

        // R7: write then immediate read of the same address
        set_bank(3, 1'b1, 1'b1, 6'd33, 9'h1e1);
        step("R7");
        set_bank(3, 1'b1, 1'b0, 6'd33, '0);
        step("R7");
        idle_all();
        step("R7");
        check("R7", 3, rd_slice(3), 9'h1e1);

        // R4: write attempt with chip enable low is ignored
        set_bank(4, 1'b0, 1'b1, 6'd5, 9'h0ff);
        step("R4");
        set_bank(4, 1'b1, 1'b0, 6'd5, '0);
        step("R4");
        idle_all();
        step("R4");
        check("R4", 4, rd_slice(4), DW'((5 * 7 + 4 * 61 + 3) & 9'h1ff));

        // R5: writes after a read leave the output on the last read word
        set_bank(5, 1'b1, 1'b0, 6'd20, '0);
        step("R5");
        set_bank(5, 1'b1, 1'b1, 6'd21, 9'h077);
        step("R5");
        set_bank(5, 1'b1, 1'b1, 6'd22, 9'h088);
        step("R5");
        idle_all();
        step("R5");
        check("R5", 5, rd_slice(5), DW'((20 * 7 + 5 * 61 + 3) & 9'h1ff));

        // R6: random mixed traffic over all banks at once
        for (int i = 0; i < 3000; i++) begin
            for (int b = 0; b < NB; b++)
                set_bank(b, ($urandom % 4) != 0, ($urandom % 2) != 0,
                         AW'($urandom), DW'($urandom));
            step("R6");
        end
        idle_all();
        step("R6");
        step("R6");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule